// File: doc/BRIEF.md
# 100 Mb/s Transmit Symbol Encoder with Raw Pass-Through

This block sits on the transmit side of a 100 Mb/s Ethernet physical layer, between the media-independent nibble interface and the serializer. On every clock it samples a 4-bit nibble, a frame enable and an error flag, then emits one registered 5-bit code group with a valid strobe. In encoded mode it wraps each frame in start and end delimiters, maps data nibbles through the 4B/5B table, puts a halt code in place of a nibble flagged as an error, and fills the gaps between frames with idle code groups.

A configuration input selects raw mode. In raw mode no table lookup and no delimiters are applied: the error flag is taken as bit 4 of a 5-bit symbol, and that symbol is passed unchanged to the output while the frame enable is high. The mode input is captured only between frames, so a frame is always sent in one mode from its first symbol to its last.

The output is a continuous symbol stream that always carries a symbol. There is no back-pressure: the serializer must take one symbol on every clock in which `sym_vld_o` is high, and the nibble side likewise never stalls. Symbol values below are written bit 4 first.

Top module: `tx_sym_enc`

## Requirements
- R1: While `rst_n` is low, `sym_o` is 11111 and `sym_vld_o` is 0; from the first rising edge after reset is released, `sym_vld_o` is 1 on every cycle.
- R2: In encoded mode, a nibble sampled with `frame_en_i` high and `frame_err_i` low, after the start pair, appears after that same edge as its 4B/5B code: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R3: In encoded mode, the first cycle with `frame_en_i` high while no frame is in progress produces J (11000), and the following cycle produces K (10001) whatever the inputs are; the nibbles and error flags of those two cycles are dropped.
- R4: In encoded mode, a data cycle with both `frame_en_i` and `frame_err_i` high produces the halt code 00100 in place of the nibble's code.
- R5: In encoded mode, the first cycle with `frame_en_i` low after the start pair produces T (01101) and the next cycle produces R (00111) whatever the inputs are; `frame_en_i` high during the R cycle is ignored, and a new frame can start on the cycle after it.
- R6: In encoded mode, every cycle with `frame_en_i` low and no frame in progress produces the idle code 11111.
- R7: In raw mode, a cycle with `frame_en_i` high produces `{frame_err_i, nib_i}` unchanged, and a cycle with `frame_en_i` low produces 11111; no J, K, T or R is inserted.
- R8: `raw_mode_i` is captured only on cycles with `frame_en_i` low and no frame in progress, and rules from the next cycle on; changes of `raw_mode_i` during a frame, including its T and R cycles, have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_en_i | input | 1 | Frame enable; marks the nibble and the error flag as valid |
| frame_err_i | input | 1 | Error flag in encoded mode; symbol bit 4 in raw mode |
| nib_i | input | 4 | Nibble to send |
| raw_mode_i | input | 1 | 1 selects raw pass-through, 0 selects 4B/5B encoding |
| sym_o | output | 5 | Registered code group toward the serializer |
| sym_vld_o | output | 1 | High on every cycle that carries a symbol |

## Verification
A wrong phase register shows at the ports within one cycle as a missing or repeated delimiter: a K that does not follow J, an R that does not follow T, or a data code where idle belongs. A mode register that moves inside a frame turns encoded data into raw nibbles, or raw nibbles into codes, on the very next symbol, so comparing every symbol against a reference model catches it at once. Table faults show only when the faulty nibble is sent, which is why every nibble value is driven in order as well as at random.

// File: rtl/tx_sym_pkg.sv
package tx_sym_pkg;

  localparam int NIB_W = 4;
  localparam int SYM_W = NIB_W + 1;

  typedef logic [SYM_W-1:0] sym_t;

  // Control code groups, bit 4 first
  localparam sym_t C_IDLE = 5'b11111;
  localparam sym_t C_J    = 5'b11000;
  localparam sym_t C_K    = 5'b10001;
  localparam sym_t C_T    = 5'b01101;
  localparam sym_t C_R    = 5'b00111;
  localparam sym_t C_HALT = 5'b00100;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_K    = 2'd1,
    PH_DATA = 2'd2,
    PH_R    = 2'd3
  } phase_t;

  function automatic sym_t nib_to_sym(input logic [NIB_W-1:0] n);
    sym_t s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tx_sym_nibble_map.sv
module tx_sym_nibble_map
  import tx_sym_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output sym_t             code_o
);

  always_comb begin
    code_o = nib_to_sym(nib_i);
  end

endmodule

// File: rtl/tx_sym_frame_ctl.sv
module tx_sym_frame_ctl
  import tx_sym_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_en_i,
  input  logic   raw_mode_i,
  output phase_t phase_o,
  output logic   mode_o
);

  phase_t phase_q, phase_d;
  logic   mode_q, mode_d;
  logic   quiet;

  // Mode may only be captured when no frame is running and none is starting
  assign quiet = (phase_q == PH_IDLE) && !frame_en_i;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (frame_en_i && !mode_q) phase_d = PH_K;
      PH_K:    phase_d = PH_DATA;
      PH_DATA: if (!frame_en_i) phase_d = PH_R;
      PH_R:    phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    mode_d = quiet ? raw_mode_i : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      mode_q  <= mode_d;
    end
  end

  assign phase_o = phase_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/tx_sym_select.sv
module tx_sym_select
  import tx_sym_pkg::*;
(
  input  phase_t           phase_i,
  input  logic             mode_i,
  input  logic             frame_en_i,
  input  logic             frame_err_i,
  input  logic [NIB_W-1:0] nib_i,
  input  sym_t             code_i,
  output sym_t             sym_o
);

  always_comb begin
    sym_o = C_IDLE;
    if (mode_i) begin
      sym_o = frame_en_i ? {frame_err_i, nib_i} : C_IDLE;
    end else begin
      case (phase_i)
        PH_IDLE: sym_o = frame_en_i ? C_J : C_IDLE;
        PH_K:    sym_o = C_K;
        PH_DATA: begin
          if (!frame_en_i)      sym_o = C_T;
          else if (frame_err_i) sym_o = C_HALT;
          else                  sym_o = code_i;
        end
        PH_R:    sym_o = C_R;
        default: sym_o = C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tx_sym_enc.sv
module tx_sym_enc
  import tx_sym_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_en_i,
  input  logic             frame_err_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             raw_mode_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             sym_vld_o
);

  phase_t phase_q;
  logic   mode_q;
  sym_t   code_w;
  sym_t   sym_d;

  tx_sym_frame_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_en_i (frame_en_i),
    .raw_mode_i (raw_mode_i),
    .phase_o    (phase_q),
    .mode_o     (mode_q)
  );

  tx_sym_nibble_map u_map (
    .nib_i  (nib_i),
    .code_o (code_w)
  );

  tx_sym_select u_sel (
    .phase_i     (phase_q),
    .mode_i      (mode_q),
    .frame_en_i  (frame_en_i),
    .frame_err_i (frame_err_i),
    .nib_i       (nib_i),
    .code_i      (code_w),
    .sym_o       (sym_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_o     <= C_IDLE;
      sym_vld_o <= 1'b0;
    end else begin
      sym_o     <= sym_d;
      sym_vld_o <= 1'b1;
    end
  end

endmodule

// File: rtl/tx_sym_enc_chk.sv
module tx_sym_enc_chk
  import tx_sym_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             frame_en_i,
  input logic             frame_err_i,
  input logic [NIB_W-1:0] nib_i,
  input logic [SYM_W-1:0] sym_o,
  input logic             sym_vld_o,
  input phase_t           phase_q,
  input logic             mode_q
);

  AST_VLD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld_o |=> sym_vld_o); // R1

  AST_J_THEN_K: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && sym_o == C_J) |=> (sym_o == C_K)); // R3

  AST_HALT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && phase_q == PH_DATA && frame_en_i && frame_err_i) |=> (sym_o == C_HALT)); // R4

  AST_T_THEN_R: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && sym_o == C_T) |=> (sym_o == C_R)); // R5

  AST_RAW_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !frame_en_i) |=> (sym_o == C_IDLE)); // R7

  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && frame_en_i) |=> (sym_o == $past({frame_err_i, nib_i}))); // R7

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en_i |=> $stable(mode_q)); // R8

endmodule

bind tx_sym_enc tx_sym_enc_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_en_i  (frame_en_i),
  .frame_err_i (frame_err_i),
  .nib_i       (nib_i),
  .sym_o       (sym_o),
  .sym_vld_o   (sym_vld_o),
  .phase_q     (phase_q),
  .mode_q      (mode_q)
);

// File: tb/tx_sym_enc_tb.sv
module tx_sym_enc_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_en_i = 1'b0;
  logic       frame_err_i = 1'b0;
  logic [3:0] nib_i = 4'h0;
  logic       raw_mode_i = 1'b0;
  logic [4:0] sym_o;
  logic       sym_vld_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference state: 0 idle, 1 K due, 2 data, 3 R due
  int m_ph  = 0;
  bit m_raw = 1'b0;

  always #5 clk = ~clk;

  tx_sym_enc u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_en_i  (frame_en_i),
    .frame_err_i (frame_err_i),
    .nib_i       (nib_i),
    .raw_mode_i  (raw_mode_i),
    .sym_o       (sym_o),
    .sym_vld_o   (sym_vld_o)
  );

  function automatic logic [4:0] ref_code(input logic [3:0] n);
    logic [4:0] tbl [16];
    tbl[0]  = 5'b11110; tbl[1]  = 5'b01001; tbl[2]  = 5'b10100; tbl[3]  = 5'b10101;
    tbl[4]  = 5'b01010; tbl[5]  = 5'b01011; tbl[6]  = 5'b01110; tbl[7]  = 5'b01111;
    tbl[8]  = 5'b10010; tbl[9]  = 5'b10011; tbl[10] = 5'b10110; tbl[11] = 5'b10111;
    tbl[12] = 5'b11010; tbl[13] = 5'b11011; tbl[14] = 5'b11100; tbl[15] = 5'b11101;
    return tbl[n];
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] d,
                      input logic byp, input string tag);
    logic [4:0] exp;
    string      t;
    int         old_ph;
    @(negedge clk);
    frame_en_i  = en;
    frame_err_i = er;
    nib_i       = d;
    raw_mode_i  = byp;
    old_ph = m_ph;
    if (m_raw) begin
      exp = en ? {er, d} : 5'b11111;
      t = "R7";
    end else begin
      case (m_ph)
        0: if (en) begin exp = 5'b11000; t = "R3"; m_ph = 1; end
           else    begin exp = 5'b11111; t = "R6"; end
        1: begin exp = 5'b10001; t = "R3"; m_ph = 2; end
        2: if (!en)    begin exp = 5'b01101; t = "R5"; m_ph = 3; end
           else if (er) begin exp = 5'b00100; t = "R4"; end
           else         begin exp = ref_code(d); t = "R2"; end
        default: begin exp = 5'b10011 ^ 5'b10100; t = "R5"; m_ph = 0; end // R code 00111
      endcase
    end
    if (old_ph == 0 && !en) m_raw = byp;
    if (tag != "") t = tag;
    @(posedge clk);
    #1;
    check(t, sym_o, exp);
    check("R1", {4'b0, sym_vld_o}, 5'b00001);
  endtask

  task automatic idle(input int n, input logic byp);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'h0, byp, "");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5077));
    // R1: reset values
    repeat (3) @(posedge clk);
    #1;
    check("R1", sym_o, 5'b11111);
    check("R1", {4'b0, sym_vld_o}, 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;

    idle(3, 1'b0);

    // R2, R3: two preamble nibbles then all sixteen values in order
    step(1'b1, 1'b1, 4'h5, 1'b0, "R3");   // error flag ignored on J
    step(1'b1, 1'b1, 4'h5, 1'b0, "R3");   // and on K
    for (int n = 0; n < 16; n++) step(1'b1, 1'b0, 4'(n), 1'b0, "R2");
    // R5: end pair
    step(1'b0, 1'b0, 4'h0, 1'b0, "R5");
    step(1'b0, 1'b0, 4'h0, 1'b0, "R5");
    idle(2, 1'b0);

    // R4: error mid frame
    step(1'b1, 1'b0, 4'h5, 1'b0, "");
    step(1'b1, 1'b0, 4'h5, 1'b0, "");
    step(1'b1, 1'b0, 4'hA, 1'b0, "R2");
    step(1'b1, 1'b1, 4'hA, 1'b0, "R4");
    step(1'b1, 1'b0, 4'hD, 1'b0, "R2");
    // R5: enable high during the R cycle is ignored, then new frame starts
    step(1'b0, 1'b0, 4'h0, 1'b0, "R5");
    step(1'b1, 1'b0, 4'h3, 1'b0, "R5");
    step(1'b1, 1'b0, 4'h3, 1'b0, "R3");
    step(1'b1, 1'b0, 4'h3, 1'b0, "R3");
    step(1'b1, 1'b0, 4'h7, 1'b0, "R2");
    step(1'b0, 1'b0, 4'h0, 1'b0, "R5");
    step(1'b0, 1'b0, 4'h0, 1'b0, "R5");

    // R3/R5: one-cycle frame
    step(1'b1, 1'b0, 4'h1, 1'b0, "R3");
    step(1'b0, 1'b0, 4'h1, 1'b0, "R3");
    step(1'b0, 1'b0, 4'h1, 1'b0, "R5");
    step(1'b0, 1'b0, 4'h1, 1'b0, "R5");
    idle(1, 1'b0);

    // R8: mode request during an encoded frame and its end pair is ignored
    step(1'b1, 1'b0, 4'h0, 1'b1, "R8");
    step(1'b1, 1'b0, 4'h0, 1'b1, "R8");
    step(1'b1, 1'b1, 4'h8, 1'b1, "R8");
    step(1'b1, 1'b0, 4'h8, 1'b1, "R8");
    step(1'b0, 1'b0, 4'h0, 1'b1, "R8");
    step(1'b0, 1'b0, 4'h0, 1'b1, "R8");
    // captured in idle, raw from next cycle
    idle(2, 1'b1);
    // R7: raw symbols including control look-alikes
    step(1'b1, 1'b1, 4'h8, 1'b1, "R7");   // 11000
    step(1'b1, 1'b0, 4'hD, 1'b1, "R7");   // 01101
    step(1'b1, 1'b0, 4'h4, 1'b0, "R8");   // request to leave ignored in frame
    step(1'b1, 1'b1, 4'hF, 1'b0, "R8");
    step(1'b0, 1'b0, 4'h0, 1'b0, "R7");   // no T in raw mode; captures 0
    step(1'b1, 1'b0, 4'h2, 1'b0, "R8");   // encoded again: J
    step(1'b1, 1'b0, 4'h2, 1'b0, "R3");
    step(1'b1, 1'b0, 4'h9, 1'b0, "R2");
    step(1'b0, 1'b0, 4'h0, 1'b0, "R5");
    step(1'b0, 1'b0, 4'h0, 1'b0, "R5");

    // random frames, random mode requests and gaps
    for (int f = 0; f < 300; f++) begin
      int gap = 1 + int'($urandom_range(0, 3));
      int len = 1 + int'($urandom_range(0, 24));
      for (int g = 0; g < gap; g++)
        step(1'b0, 1'($urandom_range(0, 1)), 4'($urandom), 1'($urandom_range(0, 2) == 0), "");
      for (int k = 0; k < len; k++)
        step(1'b1, 1'($urandom_range(0, 15) == 0), 4'($urandom),
             1'($urandom_range(0, 2) == 0), "");
    end
    idle(4, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule